// File: doc/BRIEF.md
# Segment Offset to Linear Address Translator

This block turns a segment-relative access into a linear address. Each access carries a 32-bit offset and a kind (plain data, instruction fetch or stack). The kind picks one of six segment registers: fetches always use the code segment and stack accesses always use the stack segment. Plain data accesses name their segment explicitly. Each segment register holds a selector, and the selector picks an entry in a 16-entry descriptor table. The entry supplies a 32-bit base and a 32-bit limit.

An offset strictly below the limit produces base plus offset one cycle later. Any other offset raises a one-cycle fault that reports which segment was used. A selector that points outside the table, or at an entry that has not been written since reset, faults the same way.

A control side writes descriptor entries and loads segment registers. A scheduler does this on a context switch, before the new process issues accesses.

Top module: `seg_xlate_top`

## Requirements
- R1: An access whose offset is strictly below the selected limit gives `out_valid`=1 and `out_addr`=base+offset on the cycle after `acc_valid`.
- R2: An offset equal to or above the limit gives `fault`=1 for exactly one cycle, with `fault_seg` set to the segment index used. `out_valid` stays 0 in that cycle, so a limit of 0 always faults.
- R3: The base+offset sum wraps modulo 2^32.
- R4: Kind 2'b01 (fetch) always uses segment 0 (code) and kind 2'b10 (stack) always uses segment 2 (stack). In both cases `acc_seg` is ignored.
- R5: Kinds 2'b00 and 2'b11 (data) use `acc_seg`. Segment 1 is the data segment and 3 to 5 are extra segments. `acc_seg` 6 or 7 faults with `fault_seg` equal to that value.
- R6: A segment register's selector picks the descriptor table entry. Reloading a segment register, or rewriting the entry it selects, changes the base and limit used by later accesses.
- R7: A selector of 16 or more, or one naming an entry not written since reset, faults like a limit violation.
- R8: After reset, all outputs are 0, no table entry is populated and all selectors are 0, so every access faults.
- R9: Table and segment register writes take effect from the next cycle. An access in the same cycle as a write uses the old values.
- R10: A segment register write with `sr_idx` 6 or 7 changes nothing.
- R11: A cycle without `acc_valid` gives neither `out_valid` nor `fault` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dt_we | input | 1 | Descriptor table write enable |
| dt_idx | input | 4 | Descriptor table entry to write |
| dt_base | input | 32 | Base value to write |
| dt_limit | input | 32 | Limit value to write |
| sr_we | input | 1 | Segment register write enable |
| sr_idx | input | 3 | Segment register to load (0 code, 1 data, 2 stack, 3-5 extra) |
| sr_sel | input | 5 | Selector value to load |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | 00 data, 01 fetch, 10 stack, 11 data |
| acc_seg | input | 3 | Segment for data accesses |
| acc_off | input | 32 | Offset within the segment |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 32 | Linear address |
| fault | output | 1 | One-cycle fault pulse |
| fault_seg | output | 3 | Segment index of the faulting access |

## Verification
A corrupted selector or descriptor entry shows up on the first access steered to that segment, one cycle after the request. It appears as a wrong `out_addr` or as a fault where a translation was expected. A wrong steering decision shows in `fault_seg` or in the base that gets added. The bench therefore gives each segment a distinct base and limit, so any mixing between segments changes the reported value. A stuck populated bit or a missed write shows only when an unwritten entry or an out-of-range selector is used, so both cases are covered directly.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int ADDR_W     = 32;
    localparam int NUM_SEG    = 6;
    localparam int SEG_IDX_W  = 3;
    localparam logic [SEG_IDX_W-1:0] SEG_CODE  = 3'd0;
    localparam logic [SEG_IDX_W-1:0] SEG_STACK = 3'd2;

    typedef enum logic [1:0] {
        ACC_DATA     = 2'b00,
        ACC_FETCH    = 2'b01,
        ACC_STACK    = 2'b10,
        ACC_DATA_ALT = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } desc_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEL_W = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [SEL_W-1:0] rd_sel,
    output desc_t            rd_desc,
    output logic             rd_hit
);
    typedef struct packed {
        desc_t [DEPTH-1:0] ent;
        logic  [DEPTH-1:0] vld;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic             sel_in_tbl;
    logic [IDX_W-1:0] rd_idx;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (32'(wr_idx) < 32'(DEPTH))) begin
            tbl_d.ent[wr_idx] = wr_desc;
            tbl_d.vld[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign sel_in_tbl = (32'(rd_sel) < 32'(DEPTH));

    generate
        if (SEL_W > IDX_W) begin : g_wide_sel
            assign rd_idx = rd_sel[IDX_W-1:0];
        end else begin : g_narrow_sel
            assign rd_idx = IDX_W'(rd_sel);
        end
    endgenerate

    assign rd_desc = sel_in_tbl ? tbl_q.ent[rd_idx] : '0;
    assign rd_hit  = sel_in_tbl && tbl_q.vld[rd_idx];

    // R9: without a write the table keeps its contents
    p_table_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));
endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
    import seg_xlate_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_IDX_W-1:0] wr_idx,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [SEG_IDX_W-1:0] rd_idx,
    output logic [SEL_W-1:0]     rd_sel
);
    typedef struct packed {
        logic [NUM_SEG-1:0][SEL_W-1:0] sel;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (wr_en && (32'(wr_idx) == i)) bank_d.sel[i] = wr_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (32'(rd_idx) == i) rd_sel = bank_q.sel[i];
        end
    end

    // R10: loads aimed past the bank leave every selector as it was
    p_bad_idx_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) >= NUM_SEG)) |=> $stable(bank_q));
endmodule

// File: rtl/seg_steer.sv
module seg_steer
    import seg_xlate_pkg::*;
(
    input  logic [1:0]           kind,
    input  logic [SEG_IDX_W-1:0] seg_req,
    output logic [SEG_IDX_W-1:0] seg_idx,
    output logic                 seg_known
);
    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_FETCH: seg_idx = SEG_CODE;
            ACC_STACK: seg_idx = SEG_STACK;
            default:   seg_idx = seg_req;
        endcase
        seg_known = (32'(seg_idx) < NUM_SEG);
    end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_xlate_pkg::*;
(
    input  logic              seg_known,
    input  logic              desc_hit,
    input  desc_t             desc,
    input  logic [ADDR_W-1:0] off,
    output logic              legal,
    output logic [ADDR_W-1:0] lin_addr
);
    logic in_range;

    always_comb begin
        in_range = (off < desc.limit);
        legal    = seg_known && desc_hit && in_range;
        lin_addr = desc.base + off;
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int DT_DEPTH = 16,
    parameter int SEL_W    = 5,
    localparam int DT_IDX_W = $clog2(DT_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dt_we,
    input  logic [DT_IDX_W-1:0]  dt_idx,
    input  logic [ADDR_W-1:0]    dt_base,
    input  logic [ADDR_W-1:0]    dt_limit,
    input  logic                 sr_we,
    input  logic [SEG_IDX_W-1:0] sr_idx,
    input  logic [SEL_W-1:0]     sr_sel,
    input  logic                 acc_valid,
    input  logic [1:0]           acc_kind,
    input  logic [SEG_IDX_W-1:0] acc_seg,
    input  logic [ADDR_W-1:0]    acc_off,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 fault,
    output logic [SEG_IDX_W-1:0] fault_seg
);
    typedef struct packed {
        logic                 vld;
        logic [ADDR_W-1:0]    addr;
        logic                 flt;
        logic [SEG_IDX_W-1:0] fseg;
    } res_t;

    res_t res_d, res_q;

    logic [SEG_IDX_W-1:0] cur_seg;
    logic                 cur_seg_known;
    logic [SEL_W-1:0]     cur_sel;
    desc_t                cur_desc;
    logic                 cur_hit;
    logic                 cur_legal;
    logic [ADDR_W-1:0]    cur_lin;

    seg_steer i_steer (
        .kind      (acc_kind),
        .seg_req   (acc_seg),
        .seg_idx   (cur_seg),
        .seg_known (cur_seg_known)
    );

    seg_reg_bank #(.SEL_W(SEL_W)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sr_we),
        .wr_idx (sr_idx),
        .wr_sel (sr_sel),
        .rd_idx (cur_seg),
        .rd_sel (cur_sel)
    );

    seg_desc_table #(.DEPTH(DT_DEPTH), .SEL_W(SEL_W)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dt_we),
        .wr_idx  (dt_idx),
        .wr_desc ({dt_base, dt_limit}),
        .rd_sel  (cur_sel),
        .rd_desc (cur_desc),
        .rd_hit  (cur_hit)
    );

    seg_limit_check i_check (
        .seg_known (cur_seg_known),
        .desc_hit  (cur_hit),
        .desc      (cur_desc),
        .off       (acc_off),
        .legal     (cur_legal),
        .lin_addr  (cur_lin)
    );

    always_comb begin
        res_d      = res_q;
        res_d.vld  = 1'b0;
        res_d.flt  = 1'b0;
        res_d.fseg = '0;
        if (acc_valid) begin
            if (cur_legal) begin
                res_d.vld  = 1'b1;
                res_d.addr = cur_lin;
            end else begin
                res_d.flt  = 1'b1;
                res_d.fseg = cur_seg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign out_addr  = res_q.addr;
    assign fault     = res_q.flt;
    assign fault_seg = res_q.fseg;

    // R2: a fault and a translation never share a cycle
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && fault));

    // R1: a translation only follows an in-limit request
    p_in_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(acc_valid) && ($past(acc_off) < $past(cur_desc.limit))));

    // R11: no result of either kind without a request
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault || out_valid) |-> $past(acc_valid));

    // R4: stack faults report the stack segment
    p_stack_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == ACC_STACK) |=> (!fault || fault_seg == SEG_STACK));

    // R4: fetch faults report the code segment
    p_fetch_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == ACC_FETCH) |=> (!fault || fault_seg == SEG_CODE));
endmodule

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
module test_seg_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dt_we = 1'b0;
    logic [3:0]  dt_idx = '0;
    logic [31:0] dt_base = '0;
    logic [31:0] dt_limit = '0;
    logic        sr_we = 1'b0;
    logic [2:0]  sr_idx = '0;
    logic [4:0]  sr_sel = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  acc_seg = '0;
    logic [31:0] acc_off = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        fault;
    logic [2:0]  fault_seg;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    seg_xlate_top i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .dt_we(dt_we), .dt_idx(dt_idx), .dt_base(dt_base), .dt_limit(dt_limit),
        .sr_we(sr_we), .sr_idx(sr_idx), .sr_sel(sr_sel),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_seg(acc_seg), .acc_off(acc_off),
        .out_valid(out_valid), .out_addr(out_addr), .fault(fault), .fault_seg(fault_seg)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  seg;
        logic [31:0] off;
        logic        flt;
        logic [31:0] addr;
        logic [2:0]  fseg;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 3'd5, 32'h0000_1FFF, 1'b0, 32'h0000_2FFF, 3'd0}, // R1 R4 fetch, acc_seg ignored
        '{2'b01, 3'd1, 32'h0000_2000, 1'b1, 32'h0,         3'd0}, // R2 fetch at limit
        '{2'b00, 3'd1, 32'h0000_00FF, 1'b0, 32'h9000_00FF, 3'd0}, // R1 R5 data seg
        '{2'b00, 3'd1, 32'h0000_0100, 1'b1, 32'h0,         3'd1}, // R2 data at limit
        '{2'b10, 3'd1, 32'h0000_1800, 1'b0, 32'h0000_0800, 3'd0}, // R3 R4 stack wraps
        '{2'b10, 3'd4, 32'h0001_0000, 1'b1, 32'h0,         3'd2}, // R2 R4 stack over limit
        '{2'b00, 3'd3, 32'h0000_0000, 1'b1, 32'h0,         3'd3}, // R2 limit zero
        '{2'b00, 3'd4, 32'h0000_007F, 1'b0, 32'h0000_507F, 3'd0}, // R5 R6 extra seg -> entry 15
        '{2'b00, 3'd5, 32'h0000_0000, 1'b1, 32'h0,         3'd5}, // R7 selector 20
        '{2'b00, 3'd6, 32'h0000_0000, 1'b1, 32'h0,         3'd6}, // R5 seg 6
        '{2'b00, 3'd7, 32'h0000_0000, 1'b1, 32'h0,         3'd7}, // R5 seg 7
        '{2'b11, 3'd0, 32'h0000_0000, 1'b0, 32'h0000_1000, 3'd0}, // R5 alt data kind
        '{2'b00, 3'd0, 32'hFFFF_FFFF, 1'b1, 32'h0,         3'd0}  // R2 max offset
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic dt_write(input logic [3:0] idx, input logic [31:0] b, input logic [31:0] l);
        dt_we = 1'b1; dt_idx = idx; dt_base = b; dt_limit = l;
        @(negedge clk);
        dt_we = 1'b0;
    endtask

    task automatic sr_write(input logic [2:0] idx, input logic [4:0] s);
        sr_we = 1'b1; sr_idx = idx; sr_sel = s;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    // drive at a falling edge; result is registered at the next rising edge
    task automatic access(input logic [1:0] k, input logic [2:0] s, input logic [31:0] o);
        acc_valid = 1'b1; acc_kind = k; acc_seg = s; acc_off = o;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [31:0] a);
        check(req, {62'd0, out_valid, fault}, {62'd0, 1'b1, 1'b0});
        check(req, {32'd0, out_addr}, {32'd0, a});
    endtask

    task automatic expect_flt(input string req, input logic [2:0] s);
        check(req, {62'd0, out_valid, fault}, {62'd0, 1'b0, 1'b1});
        check(req, {61'd0, fault_seg}, {61'd0, s});
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        check("R8 reset outputs", {60'd0, out_valid, fault, fault_seg != 0, 1'b0}, 64'd0);
        access(2'b01, 3'd0, 32'h0);
        expect_flt("R8 empty table faults", 3'd0);

        dt_write(4'd0,  32'h0000_1000, 32'h0000_2000);
        dt_write(4'd1,  32'h9000_0000, 32'h0000_0100);
        dt_write(4'd2,  32'hFFFF_F000, 32'h0001_0000);
        dt_write(4'd3,  32'h4000_0000, 32'h0000_0000);
        dt_write(4'd15, 32'h0000_5000, 32'h0000_0080);
        sr_write(3'd0, 5'd0);
        sr_write(3'd1, 5'd1);
        sr_write(3'd2, 5'd2);
        sr_write(3'd3, 5'd3);
        sr_write(3'd4, 5'd15);
        sr_write(3'd5, 5'd20);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].kind, VECS[i].seg, VECS[i].off);
            if (VECS[i].flt) expect_flt($sformatf("R2/R5 vector %0d", i), VECS[i].fseg);
            else             expect_ok($sformatf("R1/R3 vector %0d", i), VECS[i].addr);
        end

        // R11 idle cycle
        @(negedge clk);
        check("R11 idle", {62'd0, out_valid, fault}, 64'd0);

        // R6 context switch: data segment now selects entry 0
        sr_write(3'd1, 5'd0);
        access(2'b00, 3'd1, 32'h10);
        expect_ok("R6 reload selector", 32'h0000_1010);
        // R6 rewrite the selected descriptor
        dt_write(4'd0, 32'h2222_0000, 32'h0000_2000);
        access(2'b00, 3'd1, 32'h10);
        expect_ok("R6 rewritten entry", 32'h2222_0010);

        // R7 unwritten entry
        sr_write(3'd1, 5'd7);
        access(2'b00, 3'd1, 32'h0);
        expect_flt("R7 unwritten entry", 3'd1);

        // R9 write and access in the same cycle: old selector used
        sr_we = 1'b1; sr_idx = 3'd1; sr_sel = 5'd1;
        acc_valid = 1'b1; acc_kind = 2'b00; acc_seg = 3'd1; acc_off = 32'h10;
        @(negedge clk);
        sr_we = 1'b0; acc_valid = 1'b0;
        expect_flt("R9 same-cycle uses old", 3'd1);
        access(2'b00, 3'd1, 32'h10);
        expect_ok("R9 new value next cycle", 32'h9000_0010);

        // R10 writes to indices 6 and 7 change nothing
        sr_write(3'd6, 5'd3);
        sr_write(3'd7, 5'd3);
        access(2'b01, 3'd0, 32'h4);
        expect_ok("R10 code seg intact", 32'h2222_0004);
        access(2'b00, 3'd1, 32'h4);
        expect_ok("R10 data seg intact", 32'h9000_0004);
        access(2'b10, 3'd0, 32'h4);
        expect_ok("R10 stack seg intact", 32'hFFFF_F004);
        access(2'b00, 3'd4, 32'h4);
        expect_ok("R10 extra seg intact", 32'h0000_5004);

        // R2 fault pulse lasts one cycle
        access(2'b00, 3'd3, 32'h0);
        expect_flt("R2 pulse", 3'd3);
        @(negedge clk);
        check("R2 pulse ends", {63'd0, fault}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule